// File: doc/BRIEF.md
# Shared-Offset Transmit/Receive Data Register

This block is one register that a simple register bus reaches at a single address. Two separate 8-bit stores sit behind the same address and the same bit range. The first is a receive store. Hardware loads it through a load-enable and load-data pair, and software can only read it. The second is a transmit store. Software can only write it, and hardware reads it on an output port. The bus direction picks the store: a write goes to the transmit store and a read returns the receive store. A read therefore never returns the value just written.

Each write to the transmit store also raises a one-cycle strobe, so transmit logic downstream can start sending. A small phase machine records what the bus did on the last clock edge. It has four states:
- `PH_IDLE`: no access.
- `PH_WRITE`: write to the register.
- `PH_READ`: read of the register.
- `PH_STRAY`: access to any other address.

The machine takes these transitions on every clock edge:
- No enable asserted: go to `PH_IDLE`.
- Read alone at the register address: go to `PH_READ`.
- Write at the register address, with or without read: go to `PH_WRITE`.
- Any access at another address: go to `PH_STRAY`.

Read data and the strobe are decoded from the current state.

Top module: `pair_reg_port`

## Requirements
- R1: After reset, `tx_data`, `tx_strobe` and `bus_rdata` are zero, and a first read of the register returns zero.
- R2: A write with `bus_addr` equal to `REG_OFFSET` (0x00) stores `bus_wdata[7:0]` into the transmit store. `tx_data` shows it from the next cycle onwards. Bits above 7 of the write data are discarded.
- R3: `tx_strobe` is high in exactly the cycle after each clock edge that accepts a register write, and low in every other cycle. Back-to-back writes keep it high for one cycle per write.
- R4: A read alone at `REG_OFFSET` returns the receive store in `bus_rdata[7:0]` during the cycle after the read edge. Bits 31:8 of `bus_rdata` are always zero.
- R5: When `hw_ld_en` is high at a clock edge, the receive store takes `hw_ld_data` at that edge. When `hw_ld_en` is low, the receive store holds its value.
- R6: A software write leaves the receive store unchanged. A later read returns the last hardware-loaded value, not the written data.
- R7: A software read leaves `tx_data` unchanged.
- R8: An access to any address other than `REG_OFFSET` has no effect: a read returns zero, and a write changes neither store nor raises `tx_strobe`.
- R9: `bus_rdata` is zero in every cycle that does not follow a register read edge.
- R10: A read and a hardware load at the same edge return the receive value from before that load. The load still takes effect for later reads.
- R11: When read and write enables are both high at the register address, the write is performed and the read is dropped, so `bus_rdata` stays zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W (8) | Byte address of the access |
| bus_wr_en | input | 1 | Write request for this cycle |
| bus_rd_en | input | 1 | Read request for this cycle |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data, valid the cycle after a read |
| hw_ld_en | input | 1 | Hardware load enable for the receive store |
| hw_ld_data | input | FIELD_W (8) | Hardware load data for the receive store |
| tx_data | output | FIELD_W (8) | Current transmit store value |
| tx_strobe | output | 1 | One-cycle mark of a register write |

## Verification
The assertions assume three things about the inputs:
- Reset is asserted from time zero.
- The enables and `hw_ld_data` never carry unknown values once reset is released.
- The `$past` terms only relate neighbouring cycles after reset.

The assertions do not assume that read and write are exclusive, because R11 defines that case. The stimulus drives every input to a known value on every cycle, changes inputs only away from the active edge, and keeps reset low until the bench has set the idle values.

// File: rtl/prf_pkg.sv
package prf_pkg;

    // Kind of bus access accepted at the most recent clock edge
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_WRITE = 2'd1,
        PH_READ  = 2'd2,
        PH_STRAY = 2'd3
    } prf_phase_e;

endpackage

// File: rtl/prf_rx_field.sv
module prf_rx_field #(
    parameter int FIELD_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ld_en,
    input  logic [FIELD_W-1:0] ld_data,
    output logic [FIELD_W-1:0] value
);

    // One flop per bit, each loaded only by the hardware side
    for (genvar b = 0; b < FIELD_W; b++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                value[b] <= 1'b0;
            end else if (ld_en) begin
                value[b] <= ld_data[b];
            end
        end
    end

    assert_rx_load_R5 : assert property (@(posedge clk) disable iff (!rst_n)
        ld_en |=> (value == $past(ld_data)));

    // Software access never reaches this store
    assert_rx_hold_R6 : assert property (@(posedge clk) disable iff (!rst_n)
        !ld_en |=> $stable(value));

endmodule

// File: rtl/prf_tx_field.sv
module prf_tx_field #(
    parameter int FIELD_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_hit,
    input  logic [FIELD_W-1:0] wr_data,
    output logic [FIELD_W-1:0] value
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            value <= '0;
        end else if (wr_hit) begin
            value <= wr_data;
        end
    end

    // Reads and stray accesses leave the transmit store alone
    assert_tx_hold_R7 : assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |=> $stable(value));

endmodule

// File: rtl/prf_bus_fsm.sv
module prf_bus_fsm
    import prf_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 32,
    parameter int FIELD_W    = 8,
    parameter int REG_OFFSET = 0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  addr,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [FIELD_W-1:0] rx_value,
    output logic               wr_hit,
    output logic [DATA_W-1:0]  rdata,
    output logic               strobe
);

    localparam int              PAD_W    = DATA_W - FIELD_W;
    localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(REG_OFFSET);

    prf_phase_e         state_q, state_d;
    logic               addr_hit;
    logic               rd_hit;
    logic [FIELD_W-1:0] snap_q;

    always_comb begin
        addr_hit = (addr == HIT_ADDR);
        wr_hit   = wr_en && addr_hit;
        rd_hit   = rd_en && !wr_en && addr_hit;
    end

    // Next phase: a write outranks a read at the register address
    always_comb begin
        unique case ({wr_en, rd_en})
            2'b00:        state_d = PH_IDLE;
            2'b01:        state_d = addr_hit ? PH_READ  : PH_STRAY;
            2'b10, 2'b11: state_d = addr_hit ? PH_WRITE : PH_STRAY;
            default:      state_d = PH_IDLE;
        endcase
    end

    // State register, plus a copy of the receive store taken at the read edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PH_IDLE;
            snap_q  <= '0;
        end else begin
            state_q <= state_d;
            if (rd_hit) begin
                snap_q <= rx_value;
            end
        end
    end

    // Outputs decoded from the phase
    always_comb begin
        rdata  = '0;
        strobe = 1'b0;
        unique case (state_q)
            PH_IDLE:  ;
            PH_WRITE: strobe = 1'b1;
            PH_READ:  rdata  = {{PAD_W{1'b0}}, snap_q};
            PH_STRAY: ;
            default:  ;
        endcase
    end

    assert_strobe_on_write_R3 : assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == HIT_ADDR) |=> strobe);

    assert_strobe_quiet_R3 : assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == HIT_ADDR) |=> !strobe);

    assert_read_value_R10 : assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && addr == HIT_ADDR) |=> (rdata[FIELD_W-1:0] == $past(rx_value)));

    assert_rdata_idle_R9 : assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && !wr_en && addr == HIT_ADDR) |=> (rdata == '0));

    always_comb begin
        if (rst_n) begin
            assert_upper_zero_R4 : assert (rdata[DATA_W-1:FIELD_W] == '0);
        end
    end

endmodule

// File: rtl/pair_reg_port.sv
module pair_reg_port #(
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 32,
    parameter int FIELD_W    = 8,
    parameter int REG_OFFSET = 0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr_en,
    input  logic               bus_rd_en,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic               hw_ld_en,
    input  logic [FIELD_W-1:0] hw_ld_data,
    output logic [FIELD_W-1:0] tx_data,
    output logic               tx_strobe
);

    logic               wr_hit;
    logic [FIELD_W-1:0] rx_value;

    prf_bus_fsm #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .FIELD_W    (FIELD_W),
        .REG_OFFSET (REG_OFFSET)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (bus_addr),
        .wr_en    (bus_wr_en),
        .rd_en    (bus_rd_en),
        .rx_value (rx_value),
        .wr_hit   (wr_hit),
        .rdata    (bus_rdata),
        .strobe   (tx_strobe)
    );

    prf_rx_field #(
        .FIELD_W (FIELD_W)
    ) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_en   (hw_ld_en),
        .ld_data (hw_ld_data),
        .value   (rx_value)
    );

    prf_tx_field #(
        .FIELD_W (FIELD_W)
    ) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_hit  (wr_hit),
        .wr_data (bus_wdata[FIELD_W-1:0]),
        .value   (tx_data)
    );

    // Transmit store follows the accepted write data one edge later
    assert_tx_capture_R2 : assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && bus_addr == ADDR_W'(REG_OFFSET)) |=> (tx_data == $past(bus_wdata[FIELD_W-1:0])));

endmodule

// File: tb/pair_reg_port_bench.sv
`timescale 1ns/1ps
module pair_reg_port_bench;

    typedef struct {
        logic [31:0] rdata;
        logic [7:0]  tx;
        logic        strobe;
        string       req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr_en = 1'b0;
    logic        bus_rd_en = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        hw_ld_en = 1'b0;
    logic [7:0]  hw_ld_data = '0;
    logic [7:0]  tx_data;
    logic        tx_strobe;

    int   n_checks = 0;
    int   n_fail   = 0;
    bit   done     = 1'b0;
    exp_t sb_q[$];

    logic [7:0] m_rx = '0;
    logic [7:0] m_tx = '0;

    always #2.5 clk = ~clk;

    pair_reg_port u_pair_reg_port (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wr_en  (bus_wr_en),
        .bus_rd_en  (bus_rd_en),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .hw_ld_en   (hw_ld_en),
        .hw_ld_data (hw_ld_data),
        .tx_data    (tx_data),
        .tx_strobe  (tx_strobe)
    );

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Driver: apply one cycle of stimulus, then queue the expected outputs
    task automatic step(input logic wr, input logic rd, input logic [7:0] addr,
                        input logic [31:0] wd, input logic ld, input logic [7:0] ldd,
                        input string req);
        exp_t e;
        logic hit;
        hit = (addr == 8'h00);
        bus_wr_en  = wr;
        bus_rd_en  = rd;
        bus_addr   = addr;
        bus_wdata  = wd;
        hw_ld_en   = ld;
        hw_ld_data = ldd;
        e.rdata  = (rd && !wr && hit) ? {24'h0, m_rx} : 32'h0;
        e.strobe = wr && hit;
        if (wr && hit) m_tx = wd[7:0];
        if (ld) m_rx = ldd;
        e.tx  = m_tx;
        e.req = req;
        @(posedge clk);
        sb_q.push_back(e);
        #1;
        bus_wr_en = 1'b0;
        bus_rd_en = 1'b0;
        hw_ld_en  = 1'b0;
    endtask

    // Monitor: compare at the falling edge after each applied cycle
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            check(e.req, "bus_rdata", bus_rdata, e.rdata);
            check(e.req, "tx_data", {24'h0, tx_data}, {24'h0, e.tx});
            check(e.req, "tx_strobe", {31'h0, tx_strobe}, {31'h0, e.strobe});
        end
    end

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #20000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset values at the ports
        check("R1", "bus_rdata", bus_rdata, 32'h0);
        check("R1", "tx_data", {24'h0, tx_data}, 32'h0);
        check("R1", "tx_strobe", {31'h0, tx_strobe}, 32'h0);
        @(posedge clk); #1;
        step(0, 1, 8'h00, 32'h0, 0, 8'h00, "R1");            // first read returns zero
        step(1, 0, 8'h00, 32'h0000_00A5, 0, 8'h00, "R2");    // write stores A5
        step(0, 0, 8'h00, 32'h0, 0, 8'h00, "R3");            // strobe falls again
        step(0, 1, 8'h00, 32'h0, 0, 8'h00, "R6");            // read gives rx (0), not A5
        step(0, 0, 8'h00, 32'h0, 1, 8'h3C, "R5");            // hardware load
        step(0, 1, 8'h00, 32'h0, 0, 8'h00, "R5");            // read returns 3C
        step(0, 0, 8'h00, 32'h0, 0, 8'h00, "R9");            // idle cycle reads zero
        step(1, 0, 8'h00, 32'hFFFF_FF11, 0, 8'h00, "R2");    // upper bits dropped
        step(0, 1, 8'h00, 32'h0, 0, 8'h00, "R6");            // still 3C after write
        step(0, 1, 8'h00, 32'h0, 0, 8'h00, "R7");            // tx stays 11 over reads
        step(1, 0, 8'h04, 32'h0000_0077, 0, 8'h00, "R8");    // stray write ignored
        step(0, 1, 8'h04, 32'h0, 0, 8'h00, "R8");            // stray read zero
        step(0, 1, 8'hFC, 32'h0, 0, 8'h00, "R8");
        step(0, 1, 8'h00, 32'h0, 1, 8'hC3, "R10");           // read with load: old 3C
        step(0, 1, 8'h00, 32'h0, 0, 8'h00, "R10");           // then C3
        step(1, 1, 8'h00, 32'h0000_005A, 0, 8'h00, "R11");   // write wins, rdata zero
        step(1, 0, 8'h00, 32'h0000_0001, 0, 8'h00, "R3");    // back-to-back writes
        step(1, 0, 8'h00, 32'h0000_0002, 0, 8'h00, "R3");
        step(1, 0, 8'h00, 32'h0000_0080, 1, 8'hFF, "R6");    // write with load
        step(0, 1, 8'h00, 32'h0, 0, 8'h00, "R4");            // reads FF, upper zero
        step(0, 0, 8'h00, 32'h0, 0, 8'h00, "R9");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        finish_run();
    end

endmodule